// File: doc/BRIEF.md
# Split-Carry Multiply-Accumulate Unit

This unit takes two operand words through a valid/ready handshake and forms their full double-width product. It then adds that product into a double-width accumulator, which is kept as a low word and a high word. A mode bit, captured together with the operands, selects whether the operands and the accumulator are treated as unsigned or as two's-complement values. The product itself can never overflow. Only the accumulation can wrap, and the unit keeps a sticky flag that records when it does.

The accumulation runs in two steps. The low words are added first and the carry out is registered. The high words are then added together with that carry. In unsigned mode the wrap flag comes from the carry out of the high-word sum. In signed mode it comes from two's-complement overflow of the high-word sum. Only one operation is in flight at a time. A synchronous clear drops any operation in progress, zeroes the accumulator and lowers the flag.

Top module: `mac_split_acc`

## Requirements
- R1: After reset, both accumulator words read zero, the overflow flag is low, `in_ready` is high and `res_valid` is low.
- R2: Operands and the mode bit are taken on a rising edge where `in_valid`, `in_ready` and not `clr` are all true. `in_ready` stays low until the result is written. While it is low, changes on `in_valid`, `in_a`, `in_b` and `in_signed` have no effect on the result.
- R3: With `in_signed` = 0, both operands are unsigned. The accumulator becomes the old accumulator plus the full unsigned product, modulo 2^64. `acc_lo` holds bits 31:0 and `acc_hi` holds bits 63:32.
- R4: With `in_signed` = 1, both operands are two's-complement. The product is sign-correct over all 64 bits before it is added.
- R5: A carry out of the low-word sum is added into the high-word sum.
- R6: In unsigned mode, a carry out of the high-word sum sets the overflow flag.
- R7: In signed mode, the overflow flag is set when both high-word addends have the same sign and the high-word sum has the opposite sign. An unsigned carry alone does not set it in this mode.
- R8: Once set, the overflow flag stays high across later results until `clr` is asserted.
- R9: `clr` zeroes both accumulator words and the flag on the next edge. It cancels any operation in flight, so no `res_valid` pulse follows. When `clr` and an offered operand coincide, `clr` wins and the operand is not taken.
- R10: `res_valid` is a one-cycle pulse exactly three rising edges after the accepting edge. The accumulator outputs change only on that edge or on a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand offer |
| in_ready | output | 1 | Unit idle and able to take operands |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_signed | input | 1 | 1 = two's-complement mode, 0 = unsigned mode |
| clr | input | 1 | Synchronous clear of accumulator and flag; cancels work in flight |
| res_valid | output | 1 | One-cycle pulse when the accumulator has been updated |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_ovf | output | 1 | Sticky accumulation-wrap flag |

## Verification
The hardest case to reach is one where the low-word carry and the mode-specific wrap rule must both be right at the same time. This needs an accumulator already near a boundary and a product that pushes it across. Random operands almost never do this. Directed sequences therefore build up the accumulator first. Repeated all-ones unsigned products force a carry out of the high word. Repeated most-negative-squared signed products cross the signed limit with no unsigned carry. A low word of all ones followed by a product of one exercises the carry between words. Random operands in both modes then run against a 128-bit reference model, with clears at intervals so the flag is exercised many times.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } mac_state_e;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int W = 32
) (
  input  logic           is_signed,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] full;

  always_comb begin
    a_ext = {{W{is_signed & a[W-1]}}, a};
    b_ext = {{W{is_signed & b[W-1]}}, b};
    full  = a_ext * b_ext;
    prod  = full;
  end
endmodule

// File: rtl/mac_add.sv
module mac_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         sovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    sovf = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic clr,
  output logic in_ready,
  output logic ld_ops,
  output logic ld_prod,
  output logic ld_low,
  output logic ld_high
);
  mac_state_e state_q;
  mac_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) state_d = ST_MUL;
        ST_MUL:  state_d = ST_LOW;
        ST_LOW:  state_d = ST_HIGH;
        ST_HIGH: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    ld_ops   = in_ready && in_valid && !clr;
    ld_prod  = (state_q == ST_MUL)  && !clr;
    ld_low   = (state_q == ST_LOW)  && !clr;
    ld_high  = (state_q == ST_HIGH) && !clr;
  end

  // R2: an accepted operand closes the handshake on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ops |=> !in_ready);

  // R10: write-back strobe exactly three edges after acceptance
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ld_ops |=> ##2 ld_high);
endmodule

// File: rtl/mac_split_acc.sv
module mac_split_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_signed,
  input  logic         clr,
  output logic         res_valid,
  output logic [W-1:0] acc_lo,
  output logic [W-1:0] acc_hi,
  output logic         acc_ovf
);
  localparam int PW = 2 * W;

  logic          rst_i_n;
  logic          ld_ops, ld_prod, ld_low, ld_high;
  logic [W-1:0]  opa_q, opb_q;
  logic          mode_q;
  logic [PW-1:0] prod_d, prod_q;
  logic [W-1:0]  lo_sum_d, lo_sum_q;
  logic          lo_cy_d, lo_cy_q;
  logic [W-1:0]  hi_sum_d;
  logic          hi_cy_d, hi_sov_d;
  logic [W-1:0]  acc_lo_q, acc_hi_q;
  logic          ovf_q, vld_q;
  logic [W-1:0]  acc_lo_d, acc_hi_d;
  logic          ovf_d, vld_d;
  logic          wrap_now;

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  mac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .in_valid(in_valid), .clr(clr),
    .in_ready(in_ready), .ld_ops(ld_ops), .ld_prod(ld_prod),
    .ld_low(ld_low), .ld_high(ld_high)
  );

  mac_mult #(.W(W)) u_mult (
    .is_signed(mode_q), .a(opa_q), .b(opb_q), .prod(prod_d)
  );

  mac_add #(.W(W)) u_add_lo (
    .a(acc_lo_q), .b(prod_q[W-1:0]), .cin(1'b0),
    .sum(lo_sum_d), .cout(lo_cy_d), .sovf()
  );

  mac_add #(.W(W)) u_add_hi (
    .a(acc_hi_q), .b(prod_q[PW-1:W]), .cin(lo_cy_q),
    .sum(hi_sum_d), .cout(hi_cy_d), .sovf(hi_sov_d)
  );

  // operand capture
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mode_q <= 1'b0;
    end else if (ld_ops) begin
      opa_q  <= in_a;
      opb_q  <= in_b;
      mode_q <= in_signed;
    end
  end

  // product stage
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     prod_q <= '0;
    else if (ld_prod) prod_q <= prod_d;
  end

  // low-word stage with carry capture
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lo_sum_q <= '0;
      lo_cy_q  <= 1'b0;
    end else if (ld_low) begin
      lo_sum_q <= lo_sum_d;
      lo_cy_q  <= lo_cy_d;
    end
  end

  // accumulator next state
  always_comb begin
    wrap_now = mode_q ? hi_sov_d : hi_cy_d;
    acc_lo_d = acc_lo_q;
    acc_hi_d = acc_hi_q;
    ovf_d    = ovf_q;
    vld_d    = 1'b0;
    if (clr) begin
      acc_lo_d = '0;
      acc_hi_d = '0;
      ovf_d    = 1'b0;
    end else if (ld_high) begin
      acc_lo_d = lo_sum_q;
      acc_hi_d = hi_sum_d;
      ovf_d    = ovf_q | wrap_now;
      vld_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      ovf_q    <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      acc_lo_q <= acc_lo_d;
      acc_hi_q <= acc_hi_d;
      ovf_q    <= ovf_d;
      vld_q    <= vld_d;
    end
  end

  assign acc_lo    = acc_lo_q;
  assign acc_hi    = acc_hi_q;
  assign acc_ovf   = ovf_q;
  assign res_valid = vld_q;

  // R8: the flag only falls through a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acc_ovf && !clr) |=> acc_ovf);

  // R9: clear empties the accumulator and suppresses any result pulse
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    clr |=> (acc_lo == '0 && acc_hi == '0 && !acc_ovf && !res_valid));

  // R10: accumulator holds outside the write-back edge
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!clr && !ld_high) |=> ($stable(acc_lo) && $stable(acc_hi)));
endmodule

// File: tb/mac_split_acc_bench.sv
module mac_split_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  typedef struct {
    logic [63:0] acc;
    logic        ovf;
    int          cyc;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_signed = 1'b0;
  logic         clr = 1'b0;
  logic         res_valid;
  logic [W-1:0] acc_lo, acc_hi;
  logic         acc_ovf;

  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   done = 0;
  exp_t sb[$];
  logic [63:0] m_acc = '0;
  logic        m_ovf = 1'b0;

  mac_split_acc #(.W(W)) u_mac_split_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed), .clr(clr),
    .res_valid(res_valid), .acc_lo(acc_lo), .acc_hi(acc_hi), .acc_ovf(acc_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // 128-bit reference of one accumulation step
  task automatic model_step(input logic [31:0] a, input logic [31:0] b, input bit sm);
    logic [127:0] pa, pb, p, s;
    pa = sm ? {{96{a[31]}}, a} : {96'b0, a};
    pb = sm ? {{96{b[31]}}, b} : {96'b0, b};
    p  = pa * pb;
    if (sm) begin
      s = {{64{m_acc[63]}}, m_acc} + {{64{p[63]}}, p[63:0]};
      if (s[64] != s[63]) m_ovf = 1'b1;
    end else begin
      s = {64'b0, m_acc} + {64'b0, p[63:0]};
      if (s[64]) m_ovf = 1'b1;
    end
    m_acc = s[63:0];
  endtask

  // driver: offer operands, push the expected outcome at the accepting edge
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit sm,
                       input string tag, input bit keep);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_signed = sm;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    if (keep) begin
      model_step(a, b, sm);
      e.acc = m_acc; e.ovf = m_ovf; e.cyc = cyc; e.tag = tag;
      sb.push_back(e);
    end
    if (!keep || tag != "R2") in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0 || !in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_acc = '0; m_ovf = 1'b0;
    chk({acc_hi, acc_lo} == 64'd0, "R9", "clear acc", {acc_hi, acc_lo}, 64'd0);
    chk(acc_ovf == 1'b0, "R9", "clear ovf", {63'd0, acc_ovf}, 64'd0);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected res_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({acc_hi, acc_lo} == e.acc, e.tag, "accumulator", {acc_hi, acc_lo}, e.acc);
        chk(acc_ovf == e.ovf, e.tag, "overflow flag", {63'd0, acc_ovf}, {63'd0, e.ovf});
        chk(cyc - e.cyc == 3, "R10", "latency", 64'(cyc - e.cyc), 64'd3);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({acc_hi, acc_lo} == 64'd0, "R1", "reset acc", {acc_hi, acc_lo}, 64'd0);
    chk(acc_ovf == 1'b0, "R1", "reset ovf", {63'd0, acc_ovf}, 64'd0);
    chk(in_ready == 1'b1, "R1", "reset ready", {63'd0, in_ready}, 64'd1);
    chk(res_valid == 1'b0, "R1", "reset valid", {63'd0, res_valid}, 64'd0);

    // R3 unsigned, R4 signed
    issue(32'd7, 32'd9, 1'b0, "R3", 1'b1);
    issue(32'hFFFF_FFFD, 32'd5, 1'b1, "R4", 1'b1);
    issue(32'h8000_0000, 32'd3, 1'b1, "R4", 1'b1);
    drain();

    // R2 busy: keep offering junk with flipped mode, ready must stay low
    issue(32'd11, 32'd13, 1'b0, "R2", 1'b1);
    in_a = 32'hDEAD_BEEF; in_b = 32'hFFFF_FFFF; in_signed = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2", "ready while busy", {63'd0, in_ready}, 64'd0);
      if (i == 2) in_valid = 1'b0;
    end
    drain();

    // R5 low-word carry into the high word
    do_clear();
    issue(32'hFFFF_FFFF, 32'd1, 1'b0, "R5", 1'b1);
    issue(32'd1, 32'd1, 1'b0, "R5", 1'b1);
    drain();
    chk({acc_hi, acc_lo} == 64'h1_0000_0000, "R5", "carry result",
        {acc_hi, acc_lo}, 64'h1_0000_0000);

    // R6 unsigned wrap, then R8 sticky
    do_clear();
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6", 1'b1);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6", 1'b1);
    issue(32'd2, 32'd3, 1'b0, "R8", 1'b1);
    issue(32'd2, 32'd3, 1'b1, "R8", 1'b1);
    drain();
    chk(acc_ovf == 1'b1, "R8", "flag held", {63'd0, acc_ovf}, 64'd1);

    // R7 signed wrap with no unsigned carry
    do_clear();
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, "R7", 1'b1);
    issue(32'h8000_0000, 32'h8000_0000, 1'b1, "R7", 1'b1);
    drain();
    // R7: unsigned carry out of the high word in signed mode, no sign change
    do_clear();
    issue(32'hFFFF_FFFF, 32'd1, 1'b1, "R7", 1'b1);
    issue(32'hFFFF_FFFF, 32'd1, 1'b1, "R7", 1'b1);
    drain();

    // R9 clear cancels in-flight work
    issue(32'd100, 32'd100, 1'b0, "R9", 1'b0);
    do_clear();
    repeat (5) @(negedge clk);
    chk({acc_hi, acc_lo} == 64'd0, "R9", "cancelled op", {acc_hi, acc_lo}, 64'd0);
    // R9 clear beats a coincident offer
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_a = 32'd50; in_b = 32'd50; in_signed = 1'b0;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk({acc_hi, acc_lo} == 64'd0, "R9", "offer during clear", {acc_hi, acc_lo}, 64'd0);
    m_acc = '0; m_ovf = 1'b0;

    // random operands, both modes, periodic clears
    for (int n = 0; n < 60; n++) begin
      logic [31:0] ra, rb;
      bit rm;
      ra = $urandom; rb = $urandom; rm = $urandom_range(1, 0) == 1;
      if (n % 4 == 0) begin ra = ra | 32'hF000_0000; rb = rb | 32'hF000_0000; end
      issue(ra, rb, rm, rm ? "R4" : "R3", 1'b1);
      if (n % 10 == 9) begin drain(); do_clear(); end
    end
    drain();

    done = 1;
    report();
  end
endmodule